// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32.768 kHz tick into a periodic interrupt. A free-running counter advances once per tick. A 4-bit rate code selects a power-of-two period, and an enable input gates the output. On a tick where the counter's low bits under the period mask are all zero, the block raises a one-cycle event strobe. The same condition sets two bits in a small interrupt flag register, and an interrupt request follows those bits.

Events fall on boundaries of the free-running count that are aligned to the period. They are not counted from the moment software enables the block. A change of code or enable therefore takes effect at the next aligned boundary, and no event fires at the moment of the change. Codes 1 and 2 are folded onto the slower codes 8 and 9. Code 0 disables the block.

Top module: `pid_top`

## Requirements
- R1: After reset, `event_o` is 0, `flag_o` is 8'h00 and `irq_o` is 0. The tick counter starts at 0, so the first tick after reset is an aligned boundary for every period.
- R2: A rate code of 0 never produces an event, whatever the enable and tick inputs are.
- R3: While `pie_i` is 0 on a tick, that tick produces no event.
- R4: For codes 3 to 15, the period is 2^(code-1) ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: Code 1 behaves as code 8 (period 128 ticks) and code 2 behaves as code 9 (period 256 ticks).
- R6: An event occurs only on a tick where the number of ticks since reset, modulo 16384, is a multiple of the period. `event_o` is high for exactly the one clock cycle after that tick.
- R7: A change of rate code or enable between ticks produces no event of its own. The next event comes at the next boundary aligned to the new period.
- R8: Each event sets `flag_o[7]` and `flag_o[6]` in the same cycle that `event_o` is high. `irq_o` is 1 while either flag bit is set. All other flag bits read 0.
- R9: `ack_i` clears both flag bits on the next clock edge. If an event occurs at the same edge, the event wins and both bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 32.768 kHz tick strobe |
| rate_i | input | 4 | Rate select code |
| pie_i | input | 1 | Periodic event enable |
| ack_i | input | 1 | Clear request for the flag register |
| event_o | output | 1 | One-cycle periodic event strobe |
| flag_o | output | 8 | Interrupt flag register; bits 7 and 6 are used |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every code from 1 to 15 with a tick on every cycle for two full periods. This separates each period length and confirms that codes 1 and 2 alias to 8 and 9. Directed runs with code 0 and with the enable low show that neither produces an event. A mid-period code change shows that the next event lands on an aligned boundary rather than one period after the write. A long random run uses sparse ticks, changes code and enable at random, and sends random acknowledges. It compares the strobe, the flags and the request with a model of the aligned count on every cycle, which also covers an acknowledge that arrives together with an event.

// File: rtl/pid_pkg.sv
package pid_pkg;
    // Codes at or below ALIAS_MAX (and nonzero) fold onto slower codes.
    localparam int ALIAS_MAX    = 2;
    localparam int ALIAS_OFFSET = 7;
    // Flag register bit positions set by a periodic event.
    localparam int FLAG_ANY_BIT = 7;
    localparam int FLAG_PER_BIT = 6;
    localparam int FLAG_W       = 8;

    typedef struct packed {
        logic any_f;
        logic per_f;
    } flag_state_t;
endpackage

// File: rtl/pid_rate_decode.sv
module pid_rate_decode #(
    parameter int RATE_W = 4,
    parameter int CNT_W  = 14
) (
    input  logic [RATE_W-1:0] code_i,
    output logic              active_o,
    output logic [CNT_W-1:0]  mask_o
);
    import pid_pkg::*;

    localparam int EFF_W = RATE_W + 1;

    logic [EFF_W-1:0] eff;

    always_comb begin
        eff = {1'b0, code_i};
        if (code_i != '0 && int'(code_i) <= ALIAS_MAX) begin
            eff = EFF_W'(int'(code_i) + ALIAS_OFFSET);
        end
        active_o = (code_i != '0);
        mask_o   = '0;
        for (int b = 0; b < CNT_W; b++) begin
            if (b < int'(eff) - 1) begin
                mask_o[b] = 1'b1;
            end
        end
    end

    always_comb begin
        assert_mask_zero_when_idle_R2: assert (active_o || mask_o == '0);
    end
endmodule

// File: rtl/pid_tick_counter.sv
module pid_tick_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    assert_count_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pid_flag_reg.sv
module pid_flag_reg (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_i,
    input  logic                       ack_i,
    output logic [pid_pkg::FLAG_W-1:0] flag_o,
    output logic                       irq_o
);
    import pid_pkg::*;

    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (ack_i) begin
            fl_d = '0;
        end
        if (set_i) begin
            fl_d.any_f = 1'b1;
            fl_d.per_f = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    always_comb begin
        flag_o               = '0;
        flag_o[FLAG_ANY_BIT] = fl_q.any_f;
        flag_o[FLAG_PER_BIT] = fl_q.per_f;
    end

    assign irq_o = fl_q.any_f | fl_q.per_f;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (flag_o[FLAG_ANY_BIT] && flag_o[FLAG_PER_BIT] && irq_o));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> (flag_o == '0 && !irq_o));
endmodule

// File: rtl/pid_top.sv
module pid_top #(
    parameter int RATE_W = 4,
    parameter int CNT_W  = (1 << RATE_W) - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              pie_i,
    input  logic              ack_i,
    output logic              event_o,
    output logic [7:0]        flag_o,
    output logic              irq_o
);
    import pid_pkg::*;

    typedef struct packed {
        logic evt;
    } top_state_t;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;
    logic             active;
    logic             hit;
    top_state_t       st_d, st_q;

    pid_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .cnt_o  (cnt)
    );

    pid_rate_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_dec (
        .code_i   (rate_i),
        .active_o (active),
        .mask_o   (mask)
    );

    always_comb begin
        st_d     = st_q;
        hit      = tick_i && pie_i && active && ((cnt & mask) == '0);
        st_d.evt = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o = st_q.evt;

    pid_flag_reg u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .ack_i  (ack_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );

    assert_code_zero_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == '0) |=> !event_o);

    assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pie_i |=> !event_o);

    assert_min_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);

    assert_event_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> $past(tick_i));

    assert_event_sets_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (flag_o[7] && flag_o[6] && irq_o));
endmodule

// File: tb/pid_top_tb.sv
`timescale 1ns/1ps
module pid_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] rate_i = 4'd0;
    logic       pie_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       event_o;
    logic [7:0] flag_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int m_cnt    = 0;
    logic [1:0] m_flag = 2'b00;
    logic exp_evt;

    always #2.5 clk = ~clk;

    pid_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rate_i(rate_i),
        .pie_i(pie_i), .ack_i(ack_i), .event_o(event_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    function automatic int period_of(input logic [3:0] code);
        int e;
        e = int'(code);
        if (e == 1 || e == 2) e = e + 7;
        return 1 << (e - 1);
    endfunction

    function automatic logic expect_event(input logic t, input logic en,
                                          input logic [3:0] code, input int c);
        if (!t || !en || code == 4'd0) return 1'b0;
        return (c % period_of(code)) == 0;
    endfunction

    task automatic check(input string tag, input logic ee, input logic [7:0] ef,
                         input logic ei);
        n_checks++;
        if (event_o !== ee || flag_o !== ef || irq_o !== ei) begin
            n_fail++;
            $display("FAIL %s: event=%0b flag=%02h irq=%0b, expected event=%0b flag=%02h irq=%0b",
                     tag, event_o, flag_o, irq_o, ee, ef, ei);
        end
    endtask

    // One clock cycle: drive at negedge, model the edge, sample after it.
    task automatic cyc(input string tag, input logic t, input logic [3:0] code,
                       input logic en, input logic ack);
        tick_i = t; rate_i = code; pie_i = en; ack_i = ack;
        exp_evt = expect_event(t, en, code, m_cnt);
        if (ack) m_flag = 2'b00;
        if (exp_evt) m_flag = 2'b11;
        if (t) m_cnt = (m_cnt + 1) % 16384;
        @(posedge clk);
        #1;
        check(tag, exp_evt, {m_flag, 6'b0}, |m_flag);
        @(negedge clk);
    endtask

    // Tick every cycle until the model count is a multiple of 'al'.
    task automatic align_to(input int al, input logic [3:0] code, input logic en);
        while ((m_cnt % al) != 0) cyc("R6", 1'b1, code, en, 1'b1);
    endtask

    initial begin
        #(200000 * 5.0 - 100);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R1", 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: the first tick after reset is aligned for the longest period.
        cyc("R1", 1'b1, 4'd15, 1'b1, 1'b0);
        cyc("R9", 1'b0, 4'd15, 1'b1, 1'b1);

        // R2: code 0 is silent.
        for (int i = 0; i < 300; i++) cyc("R2", 1'b1, 4'd0, 1'b1, 1'b0);
        // R3: enable low is silent.
        for (int i = 0; i < 300; i++) cyc("R3", 1'b1, 4'd3, 1'b0, 1'b0);

        // R4 and R5: every nonzero code over two periods, ticking each cycle.
        for (int c = 1; c < 16; c++) begin
            align_to(period_of(4'(c)), 4'(c), 1'b0);
            for (int i = 0; i < 2 * period_of(4'(c)); i++)
                cyc((c <= 2) ? "R5" : "R4", 1'b1, 4'(c), 1'b1, (i % 7) == 3);
        end

        // R7: switch from code 3 to code 6 mid-period; next event on a 32 boundary.
        align_to(32, 4'd3, 1'b0);
        for (int i = 0; i < 6; i++) cyc("R7", 1'b1, 4'd3, 1'b1, 1'b1);
        for (int i = 0; i < 70; i++) cyc("R7", 1'b1, 4'd6, 1'b1, 1'b1);
        // R7: enable rising off-boundary gives no immediate event.
        align_to(16, 4'd5, 1'b0);
        cyc("R7", 1'b1, 4'd5, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++) cyc("R7", 1'b1, 4'd5, 1'b1, 1'b0);

        // R9: acknowledge in the same cycle as an event; event wins.
        align_to(8, 4'd4, 1'b0);
        cyc("R9", 1'b1, 4'd4, 1'b1, 1'b1);
        cyc("R9", 1'b0, 4'd4, 1'b1, 1'b1);

        // R6/R8: random sparse ticks, random codes, enables and acks.
        begin
            logic [3:0] code = 4'd3;
            logic en = 1'b1;
            for (int i = 0; i < 40000; i++) begin
                if (($urandom % 400) == 0) code = 4'($urandom % 8);
                if (($urandom % 300) == 0) en = 1'($urandom);
                cyc((i % 2 == 0) ? "R6" : "R8", 1'($urandom % 2), code, en,
                    ($urandom % 16) == 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule